// File: doc/BRIEF.md
# Genlock Line and Field Reset Generator

This block derives the two reset strobes that hold a host graphics chipset in step with an external video source. A free-running line counter divides the master pixel clock by the line length and emits a one-cycle regenerated horizontal pulse at the start of every line. Nothing stops or restarts that pulse once reset is released, so the host always sees an unbroken line cadence.

A horizontal state machine turns every other regenerated pulse into a low-active line reset of fixed minimum length. Both of its edges are moved onto rising edges of the host's color clock, which is first passed through a two-stage synchronizer. A vertical state machine counts pulses of the detected input horizontal sync after every other detected vertical sync. It drives a low-active field reset that begins on a chosen sync pulse and lasts exactly one line, from that pulse to the next.

States of the horizontal machine: `H_IDLE` (output high), `H_ARM` (waiting for a color clock edge to assert), `H_LOW` (output low, counting the width), `H_REL` (output low, waiting for a color clock edge to release). Its transitions are: H_IDLE to H_ARM on an armed regenerated pulse with no color clock edge; H_IDLE to H_LOW on an armed pulse that coincides with one; H_ARM to H_LOW on a color clock edge; H_LOW to H_REL when the width count ends with no edge; H_LOW to H_IDLE when the width ends on an edge; H_REL to H_IDLE on an edge. States of the vertical machine: `V_IDLE` (output high), `V_COUNT` (counting horizontal syncs), `V_LOW` (output low). Its transitions are: V_IDLE to V_COUNT on an armed vertical sync; V_COUNT to V_LOW on the horizontal sync that completes the count; V_LOW to V_IDLE on the next horizontal sync.

Top module: `genlock_reset_gen`

## Requirements
- R1: `hreg_pulse` is high for exactly one cycle every LINE_LEN cycles. It is high in the cycle right after reset is released, and again after every LINE_LEN rising clock edges, whatever the other inputs do.
- R2: While reset is held, and in the cycle it is released, `h2_rst_n` and `v2_rst_n` are both high (1).
- R3: Regenerated pulses are numbered 0, 1, 2, ... from reset. Only pulses with an even number start a line reset. A pulse with an odd number leaves `h2_rst_n` high.
- R4: `h2_rst_n` changes only at a clock edge e where `color_clk` was sampled 1 at edge e-2 and 0 at edge e-3. Such an edge is called eligible, and samples taken before reset release count as 0.
- R5: For an even pulse seen in the cycle before edge p, `h2_rst_n` falls at the first eligible edge at or after p. If it fell at edge n, it rises at the first eligible edge at or after n+HRST_LEN.
- R6: Vertical syncs are numbered 0, 1, 2, ... from reset. A vertical sync with an even number that arrives while no field reset is in progress starts one. Syncs with an odd number start nothing.
- R7: After a starting vertical sync, `v2_rst_n` falls at the edge that samples the VDELAY-th following `hsync_in` pulse, and rises at the edge that samples the next one. An `hsync_in` in the same cycle as the vertical sync is not counted.
- R8: A vertical sync during a field reset in progress does not restart or shift it. It still advances the vertical sync numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| color_clk | input | 1 | Host color clock, asynchronous level, synchronized inside |
| hsync_in | input | 1 | One-cycle pulse per detected input line sync |
| vsync_in | input | 1 | One-cycle pulse per detected input field sync |
| hreg_pulse | output | 1 | Regenerated horizontal pulse, one cycle per line |
| h2_rst_n | output | 1 | Low-active line reset, every other line |
| v2_rst_n | output | 1 | Low-active field reset, every other field, one line wide |

## Verification
Two pairs of events can land in the same cycle. An armed regenerated pulse can arrive together with a synchronized color clock edge, so the line reset must skip `H_ARM` and fall on that edge. A vertical sync can arrive together with a horizontal sync, and that horizontal sync must not be counted. The bench sets the line period, the color clock periods and the sync phases so that both collisions happen. It then compares the outputs in every cycle against an event model built from the requirement rules. At each change of the line reset it also checks that the edge is eligible.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [1:0] {
        H_IDLE = 2'd0,
        H_ARM  = 2'd1,
        H_LOW  = 2'd2,
        H_REL  = 2'd3
    } h2_state_t;

    typedef enum logic [1:0] {
        V_IDLE  = 2'd0,
        V_COUNT = 2'd1,
        V_LOW   = 2'd2
    } v2_state_t;

endpackage

// File: rtl/rg_line_counter.sv
module rg_line_counter #(
    parameter int LINE_LEN = 1820
) (
    input  logic clk,
    input  logic rst_n,
    output logic line_start
);
    localparam int CW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LINE_LEN - 1);

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (pos_q == LAST) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_comb begin
        line_start = (pos_q == '0);
    end
endmodule

// File: rtl/rg_cc_edge.sv
module rg_cc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cc_async,
    output logic cc_rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= cc_async;
        end
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q[i] <= 1'b0;
            end else begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    always_comb begin
        cc_rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    end
endmodule

// File: rtl/rg_h2_fsm.sv
module rg_h2_fsm
    import rg_pkg::*;
#(
    parameter int HRST_LEN = 916
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic cc_rise,
    output logic h2_rst_n
);
    localparam int WW = $clog2(HRST_LEN + 1);
    localparam logic [WW-1:0] WLAST = WW'(HRST_LEN - 1);

    h2_state_t state_q, state_d;
    logic      odd_q;
    logic [WW-1:0] width_q;
    logic      width_done;
    logic      arm;

    always_comb begin
        width_done = (width_q == WLAST);
        arm        = line_start & ~odd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= H_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
        end else if (line_start) begin
            odd_q <= ~odd_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != H_LOW) begin
            width_q <= '0;
        end else if (!width_done) begin
            width_q <= width_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE: if (arm)        state_d = cc_rise ? H_LOW : H_ARM;
            H_ARM:  if (cc_rise)    state_d = H_LOW;
            H_LOW:  if (width_done) state_d = cc_rise ? H_IDLE : H_REL;
            H_REL:  if (cc_rise)    state_d = H_IDLE;
        endcase
    end

    always_comb begin
        h2_rst_n = !(state_q == H_LOW || state_q == H_REL);
    end
endmodule

// File: rtl/rg_v2_fsm.sv
module rg_v2_fsm
    import rg_pkg::*;
#(
    parameter int VDELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic vsync_in,
    output logic v2_rst_n
);
    localparam int LW = $clog2(VDELAY + 1);
    localparam logic [LW-1:0] LLAST = LW'(VDELAY - 1);

    v2_state_t state_q, state_d;
    logic      odd_q;
    logic [LW-1:0] lines_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= V_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
        end else if (vsync_in) begin
            odd_q <= ~odd_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != V_COUNT) begin
            lines_q <= '0;
        end else if (hsync_in) begin
            lines_q <= lines_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            V_IDLE:  if (vsync_in && !odd_q)          state_d = V_COUNT;
            V_COUNT: if (hsync_in && lines_q == LLAST) state_d = V_LOW;
            V_LOW:   if (hsync_in)                    state_d = V_IDLE;
            default:                                  state_d = V_IDLE;
        endcase
    end

    always_comb begin
        v2_rst_n = (state_q != V_LOW);
    end
endmodule

// File: rtl/genlock_reset_gen.sv
module genlock_reset_gen #(
    parameter int LINE_LEN    = 1820,
    parameter int HRST_LEN    = 916,
    parameter int VDELAY      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic color_clk,
    input  logic hsync_in,
    input  logic vsync_in,
    output logic hreg_pulse,
    output logic h2_rst_n,
    output logic v2_rst_n
);
    logic cc_rise;

    rg_line_counter #(.LINE_LEN(LINE_LEN)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (hreg_pulse)
    );

    rg_cc_edge #(.STAGES(SYNC_STAGES)) u_cc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cc_async (color_clk),
        .cc_rise  (cc_rise)
    );

    rg_h2_fsm #(.HRST_LEN(HRST_LEN)) u_h2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (hreg_pulse),
        .cc_rise    (cc_rise),
        .h2_rst_n   (h2_rst_n)
    );

    rg_v2_fsm #(.VDELAY(VDELAY)) u_v2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_in (hsync_in),
        .vsync_in (vsync_in),
        .v2_rst_n (v2_rst_n)
    );
endmodule

// File: rtl/rg_reset_checker.sv
module rg_reset_checker (
    input logic clk,
    input logic rst_n,
    input logic hreg_pulse,
    input logic cc_rise,
    input logic hsync_in,
    input logic h2_rst_n,
    input logic v2_rst_n
);
    p_hreg_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hreg_pulse |=> !hreg_pulse);

    p_h2_fall_on_cc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h2_rst_n) |-> $past(cc_rise));

    p_h2_rise_on_cc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2_rst_n) |-> $past(cc_rise));

    p_v2_fall_on_hsync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v2_rst_n) |-> $past(hsync_in));

    p_v2_rise_on_hsync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v2_rst_n) |-> $past(hsync_in));
endmodule

bind genlock_reset_gen rg_reset_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hreg_pulse (hreg_pulse),
    .cc_rise    (cc_rise),
    .hsync_in   (hsync_in),
    .h2_rst_n   (h2_rst_n),
    .v2_rst_n   (v2_rst_n)
);

// File: tb/genlock_reset_gen_test.sv
module genlock_reset_gen_test;
    localparam int L  = 40;
    localparam int W  = 13;
    localparam int VD = 3;
    localparam int END_PC = 2200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic color_clk = 1'b0;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic hreg_pulse, h2_rst_n, v2_rst_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    genlock_reset_gen #(.LINE_LEN(L), .HRST_LEN(W), .VDELAY(VD), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .color_clk(color_clk),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hreg_pulse(hreg_pulse), .h2_rst_n(h2_rst_n), .v2_rst_n(v2_rst_n)
    );

    function automatic bit cc_at(int k);
        if (k <= 0)        return 1'b0;
        else if (k < 650)  return (k % 8) < 4;
        else if (k < 1300) return (k % 6) < 2;
        else               return (k % 11) < 5;
    endfunction

    function automatic bit elig(int e);
        return cc_at(e - 2) && !cc_at(e - 3);
    endfunction

    function automatic bit hs_at(int k);
        return (k > 0) && (k % 40 == 7);
    endfunction

    function automatic bit vs_at(int k);
        case (k)
            47, 300, 420, 440, 700, 900, 1100, 1300, 1500, 1700, 1900, 2100: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp, int pc);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, pc, act, exp);
        end
    endtask

    initial begin
        int hmode, hstart, vmode, vlines, vpar;
        bit h2_prev;
        hmode = 0; hstart = 0; vmode = 0; vlines = 0; vpar = 0;
        repeat (4) @(negedge clk);
        // R2: outputs high while reset is held
        check(h2_rst_n == 1'b1, "R2 h2 in reset", int'(h2_rst_n), 1, -1);
        check(v2_rst_n == 1'b1, "R2 v2 in reset", int'(v2_rst_n), 1, -1);
        rst_n = 1'b1;
        #1;
        check(h2_rst_n == 1'b1, "R2 h2 after release", int'(h2_rst_n), 1, 0);
        check(v2_rst_n == 1'b1, "R2 v2 after release", int'(v2_rst_n), 1, 0);
        check(hreg_pulse == 1'b1, "R1 first pulse", int'(hreg_pulse), 1, 0);
        h2_prev = h2_rst_n;
        color_clk = cc_at(1); hsync_in = hs_at(1); vsync_in = vs_at(1);
        for (int pc = 1; pc <= END_PC; pc++) begin
            bit exp_h2, exp_v2, exp_hreg;
            @(negedge clk);
            // horizontal model (R3 R5)
            if (hmode == 0 && (pc - 1) % L == 0 && ((pc - 1) / L) % 2 == 0) hmode = 1;
            if (hmode == 1 && elig(pc)) begin
                hmode = 2; hstart = pc;
            end else if (hmode == 2 && pc >= hstart + W && elig(pc)) begin
                hmode = 0;
            end
            // vertical model (R6 R7 R8)
            if (vmode == 0) begin
                if (vs_at(pc)) begin
                    if (vpar % 2 == 0) begin vmode = 1; vlines = 0; end
                    vpar++;
                end
            end else begin
                if (vs_at(pc)) vpar++;
                if (vmode == 1 && hs_at(pc)) begin
                    vlines++;
                    if (vlines == VD) vmode = 2;
                end else if (vmode == 2 && hs_at(pc)) begin
                    vmode = 0;
                end
            end
            exp_hreg = (pc % L == 0);
            exp_h2   = (hmode != 2);
            exp_v2   = (vmode != 2);
            check(hreg_pulse == exp_hreg, "R1 regenerated pulse", int'(hreg_pulse), int'(exp_hreg), pc);
            check(h2_rst_n == exp_h2, "R3 R5 line reset level", int'(h2_rst_n), int'(exp_h2), pc);
            check(v2_rst_n == exp_v2, "R6 R7 field reset level", int'(v2_rst_n), int'(exp_v2), pc);
            if (h2_rst_n != h2_prev)
                check(elig(pc), "R4 line reset edge on color clock", 0, 1, pc);
            h2_prev = h2_rst_n;
            // R8: sync at 440 must not move the interval started at 420 (low 527..566)
            if (pc == 530) check(v2_rst_n == 1'b0, "R8 interval kept", int'(v2_rst_n), 0, pc);
            if (pc == 567) check(v2_rst_n == 1'b1, "R8 interval end", int'(v2_rst_n), 1, pc);
            // R6: odd sync at 300 starts nothing
            if (pc == 410) check(v2_rst_n == 1'b1, "R6 odd field", int'(v2_rst_n), 1, pc);
            color_clk = cc_at(pc + 1);
            hsync_in  = hs_at(pc + 1);
            vsync_in  = vs_at(pc + 1);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule